// File: doc/BRIEF.md
# Strided Two-Dimensional Burst Request Generator

This block turns one two-dimensional transfer descriptor into an ordered stream of memory burst requests. A descriptor names a base address, a row length, a row count and the distance between the starts of consecutive rows. The block walks the rows in order and cuts each row into bursts no larger than a configured cap. It presents one request at a time on a valid/ready handshake. Each request carries a start address, a beat count in AxLEN style and a byte-enable mask for its final beat. One cycle after the final burst of the final row is accepted, the block pulses a completion flag.

Lengths arrive encoded as value-minus-one. The base address and the stride are silently rounded down to the bus width. The burst cap is the smaller of two limits: a configured power-of-two byte size, and the beat limit of the selected memory protocol generation (256 beats, or 16 beats in the older mode). A parameter can remove two-dimensional support, and then every descriptor yields exactly one row.

Deasserting the enable stops new work without breaking the handshake. A request that is already on the port stays there until it is taken, and after that nothing further is issued.

Top module: `stride_burst_gen`

## Requirements
- R1: A descriptor with row field X and row-count field Y moves X+1 bytes per row over Y+1 rows.
- R2: Row N of a descriptor starts at the aligned base plus N times the aligned stride, and within a row each burst starts where the previous one ended.
- R3: With ENABLE_2D = 0 the row-count field is ignored and exactly one row is produced.
- R4: The bits of the base and stride below log2(BUS_BYTES) are treated as zero, so every issued address is bus aligned.
- R5: A row is issued as full bursts of the cap size followed by one final burst carrying the remainder, and req_len equals the beat count minus one.
- R6: The cap in bytes is min(MAX_BURST_BYTES, P*BUS_BYTES), where P is 256 beats for AXI3_MODE = 0 and 16 beats for AXI3_MODE = 1.
- R7: req_last_strb has bit i set for byte lane i of the burst's final beat. It is all ones except on the final burst of a row whose byte count modulo BUS_BYTES is a nonzero k, where it equals (1<<k)-1.
- R8: Once req_valid is high it stays high, and the address, length and mask stay unchanged, until req_ready is sampled high.
- R9: done is high for exactly the one cycle after the final burst of a descriptor is accepted, and is low after reset.
- R10: If enable is low when a burst is accepted and bursts remain, no further request is issued and no done pulse follows.
- R11: desc_ready is high only while no request is outstanding and enable is high, and a request appears only in the cycle after a descriptor is accepted or after a burst handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows descriptor acceptance and continued issue |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_base | input | ADDR_W | Start address of the first row |
| desc_xlen | input | XLEN_W | Bytes per row minus one |
| desc_ylen | input | YLEN_W | Rows minus one |
| desc_stride | input | ADDR_W | Byte distance between row starts |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Burst request taken |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | 8 | Beats in burst minus one |
| req_last_strb | output | BUS_BYTES | Byte enables for the final beat |
| req_row_end | output | 1 | Burst closes its row |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first request of a descriptor is due one cycle after the descriptor handshake. Each following request is due one cycle after the previous burst handshake, and the done pulse is due one cycle after the final handshake, since each of these passes through exactly one register. The bench drives inputs just after the rising edge and compares every output on the falling edge against a behavioural model. That model is advanced once per cycle with the same handshake decisions the design sees at the next edge, so every comparison lands in the cycle the result is due. Random back-pressure stretches requests over many cycles to exercise holding, and a second instance with one row and the smaller protocol limit covers the parameter variants.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  typedef enum logic [0:0] {
    SBG_IDLE = 1'b0,
    SBG_RUN  = 1'b1
  } sbg_state_e;

  localparam int unsigned SBG_AXLEN_W = 8;

endpackage

// File: rtl/sbg_burst_calc.sv
module sbg_burst_calc #(
  parameter int unsigned REM_W       = 17,
  parameter int unsigned BUS_BYTES   = 8,
  parameter int unsigned BURST_BYTES = 256
) (
  input  logic [REM_W-1:0]     rem,
  output logic [REM_W-1:0]     burst_bytes,
  output logic [7:0]           len,
  output logic [BUS_BYTES-1:0] strb,
  output logic                 row_end
);

  localparam int unsigned SH = $clog2(BUS_BYTES);

  logic [REM_W-1:0] bytes_m1;

  always_comb begin
    row_end     = (rem <= REM_W'(BURST_BYTES));
    burst_bytes = row_end ? rem : REM_W'(BURST_BYTES);
    bytes_m1    = burst_bytes - REM_W'(1);
    len         = 8'(bytes_m1 >> SH);
  end

  generate
    if (SH == 0) begin : g_byte_bus
      assign strb = '1;
    end else begin : g_wide_bus
      logic [SH-1:0]        tail;
      logic [BUS_BYTES-1:0] partial;
      always_comb begin
        tail    = rem[SH-1:0];
        partial = (BUS_BYTES'(1) << tail) - BUS_BYTES'(1);
        strb    = (row_end && (tail != '0)) ? partial : '1;
      end
    end
  endgenerate

endmodule

// File: rtl/sbg_row_seq.sv
module sbg_row_seq #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned YLEN_W    = 12,
  parameter bit          ENABLE_2D = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [YLEN_W-1:0] rows_m1,
  output logic [ADDR_W-1:0] next_row_addr,
  output logic              last_row
);

  logic [ADDR_W-1:0] row_start_q, row_start_d;
  logic [ADDR_W-1:0] stride_q, stride_d;
  logic [YLEN_W-1:0] left_q, left_d;
  logic              row_en;

  always_comb begin
    row_start_d = row_start_q;
    stride_d    = stride_q;
    left_d      = left_q;
    row_en      = load | step;
    if (load) begin
      row_start_d = base;
      stride_d    = stride;
      left_d      = ENABLE_2D ? rows_m1 : '0;
    end else if (step) begin
      row_start_d = row_start_q + stride_q;
      left_d      = left_q - YLEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_start_q <= '0;
      stride_q    <= '0;
      left_q      <= '0;
    end else if (row_en) begin
      row_start_q <= row_start_d;
      stride_q    <= stride_d;
      left_q      <= left_d;
    end
  end

  assign next_row_addr = row_start_q + stride_q;
  assign last_row      = (left_q == '0);

  // R3: the sequencer is never asked to move beyond the final row
  a_r3_no_extra_row: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !last_row);

endmodule

// File: rtl/stride_burst_gen.sv
module stride_burst_gen #(
  parameter int unsigned ADDR_W          = 32,
  parameter int unsigned XLEN_W          = 16,
  parameter int unsigned YLEN_W          = 12,
  parameter int unsigned BUS_BYTES       = 8,
  parameter int unsigned MAX_BURST_BYTES = 256,
  parameter bit          AXI3_MODE       = 1'b0,
  parameter bit          ENABLE_2D       = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 desc_valid,
  output logic                 desc_ready,
  input  logic [ADDR_W-1:0]    desc_base,
  input  logic [XLEN_W-1:0]    desc_xlen,
  input  logic [YLEN_W-1:0]    desc_ylen,
  input  logic [ADDR_W-1:0]    desc_stride,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [7:0]           req_len,
  output logic [BUS_BYTES-1:0] req_last_strb,
  output logic                 req_row_end,
  output logic                 done
);
  import sbg_pkg::*;

  localparam int unsigned PROTO_BEATS = AXI3_MODE ? 16 : 256;
  localparam int unsigned CFG_BEATS   = MAX_BURST_BYTES / BUS_BYTES;
  localparam int unsigned BURST_BEATS = (CFG_BEATS < PROTO_BEATS) ? CFG_BEATS : PROTO_BEATS;
  localparam int unsigned BURST_BYTES = BURST_BEATS * BUS_BYTES;
  localparam int unsigned REM_W       = XLEN_W + 1;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BUS_BYTES - 1);

  sbg_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [XLEN_W-1:0] xlen_q, xlen_d;
  logic              done_q, done_d;
  logic              run_en;

  logic [ADDR_W-1:0] base_al, stride_al, next_row_addr;
  logic [REM_W-1:0]  burst_bytes;
  logic              row_end, last_row;
  logic              accept, handshake, row_step;

  assign base_al   = desc_base & ~LOW_MASK;
  assign stride_al = desc_stride & ~LOW_MASK;

  sbg_burst_calc #(
    .REM_W      (REM_W),
    .BUS_BYTES  (BUS_BYTES),
    .BURST_BYTES(BURST_BYTES)
  ) u_calc (
    .rem        (rem_q),
    .burst_bytes(burst_bytes),
    .len        (req_len),
    .strb       (req_last_strb),
    .row_end    (row_end)
  );

  sbg_row_seq #(
    .ADDR_W   (ADDR_W),
    .YLEN_W   (YLEN_W),
    .ENABLE_2D(ENABLE_2D)
  ) u_rows (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .step         (row_step),
    .base         (base_al),
    .stride       (stride_al),
    .rows_m1      (desc_ylen),
    .next_row_addr(next_row_addr),
    .last_row     (last_row)
  );

  assign desc_ready = (state_q == SBG_IDLE) && enable;
  assign accept     = desc_valid && desc_ready;
  assign req_valid  = (state_q == SBG_RUN);
  assign handshake  = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    rem_d    = rem_q;
    xlen_d   = xlen_q;
    done_d   = 1'b0;
    row_step = 1'b0;
    if (accept) begin
      state_d = SBG_RUN;
      addr_d  = base_al;
      rem_d   = {1'b0, desc_xlen} + REM_W'(1);
      xlen_d  = desc_xlen;
    end else if (handshake) begin
      if (row_end && last_row) begin
        state_d = SBG_IDLE;
        done_d  = 1'b1;
      end else if (!enable) begin
        state_d = SBG_IDLE;
      end else if (!row_end) begin
        addr_d = addr_q + ADDR_W'(burst_bytes);
        rem_d  = rem_q - burst_bytes;
      end else begin
        row_step = 1'b1;
        addr_d   = next_row_addr;
        rem_d    = {1'b0, xlen_q} + REM_W'(1);
      end
    end
    run_en = accept | handshake;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SBG_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      xlen_q  <= '0;
    end else if (run_en) begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      xlen_q  <= xlen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign req_addr    = addr_q;
  assign req_row_end = row_end;
  assign done        = done_q;

  // R8: a presented request is frozen until it is taken
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_len) && $stable(req_last_strb));

  // R4: addresses on the port are bus aligned
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_addr & LOW_MASK) == '0));

  // R5, R6: never more beats than the effective cap
  a_r5_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_len) <= int'(BURST_BEATS) - 1));

  // R9: completion follows a burst handshake
  a_r9_done_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && req_ready));

  // R11: no request appears without a descriptor being taken
  a_r11_no_spontaneous: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && !(desc_valid && desc_ready) |=> !req_valid);

  // R10: nothing new starts while disabled
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && !enable |=> !req_valid);

endmodule

// File: tb/stride_burst_gen_bench.sv
module stride_burst_gen_bench;

  typedef struct {
    logic [31:0] a;
    logic [7:0]  l;
    logic [7:0]  s;
    logic        e;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        enable = 1'b0;
  logic        sel = 1'b0;
  logic        desc_valid = 1'b0;
  logic [31:0] desc_base = '0;
  logic [15:0] desc_xlen = '0;
  logic [11:0] desc_ylen = '0;
  logic [31:0] desc_stride = '0;
  logic        req_ready = 1'b0;
  logic        rand_on = 1'b0;

  logic d1_dr, d1_v, d1_e, d1_done, d2_dr, d2_v, d2_e, d2_done;
  logic [31:0] d1_a, d2_a;
  logic [7:0]  d1_l, d2_l, d1_s, d2_s;

  stride_burst_gen u_stride_burst_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .desc_valid(desc_valid && !sel), .desc_ready(d1_dr),
    .desc_base(desc_base), .desc_xlen(desc_xlen), .desc_ylen(desc_ylen),
    .desc_stride(desc_stride),
    .req_valid(d1_v), .req_ready(req_ready && !sel), .req_addr(d1_a),
    .req_len(d1_l), .req_last_strb(d1_s), .req_row_end(d1_e), .done(d1_done));

  stride_burst_gen #(.AXI3_MODE(1'b1), .ENABLE_2D(1'b0)) u_flat (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .desc_valid(desc_valid && sel), .desc_ready(d2_dr),
    .desc_base(desc_base), .desc_xlen(desc_xlen), .desc_ylen(desc_ylen),
    .desc_stride(desc_stride),
    .req_valid(d2_v), .req_ready(req_ready && sel), .req_addr(d2_a),
    .req_len(d2_l), .req_last_strb(d2_s), .req_row_end(d2_e), .done(d2_done));

  wire        o_dr   = sel ? d2_dr : d1_dr;
  wire        o_v    = sel ? d2_v : d1_v;
  wire [31:0] o_a    = sel ? d2_a : d1_a;
  wire [7:0]  o_l    = sel ? d2_l : d1_l;
  wire [7:0]  o_s    = sel ? d2_s : d1_s;
  wire        o_e    = sel ? d2_e : d1_e;
  wire        o_done = sel ? d2_done : d1_done;

  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  string tag = "R11";

  exp_t  q[$];
  bit    m_busy = 1'b0;
  bit    m_done = 1'b0;
  int    scen_hs = 0;
  int    scen_exp = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic void build();
    int unsigned cap   = sel ? 128 : 256;
    int unsigned rows  = sel ? 1 : int'(desc_ylen) + 1;
    logic [31:0] base  = desc_base & ~32'h7;
    logic [31:0] strd  = desc_stride & ~32'h7;
    q.delete();
    for (int r = 0; r < int'(rows); r++) begin
      int unsigned rem = int'(desc_xlen) + 1;
      logic [31:0] a = base + strd * r;
      while (rem > 0) begin
        exp_t        x;
        int unsigned b = (rem > cap) ? cap : rem;
        bit          last = (rem <= cap);
        x.a = a;
        x.l = 8'((b - 1) / 8);
        x.s = (last && (rem % 8) != 0) ? 8'((1 << (rem % 8)) - 1) : 8'hff;
        x.e = last;
        q.push_back(x);
        a   = a + b;
        rem = rem - b;
      end
    end
    scen_exp = q.size();
  endfunction

  // Reference model and per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit hs, acc;
      check(o_v == m_busy, "R8/R10/R11", "req_valid", 32'(o_v), 32'(m_busy));
      if (m_busy && o_v && q.size() > 0) begin
        check(o_a == q[0].a, tag, "R2 address", o_a, q[0].a);
        check(o_l == q[0].l, tag, "R5 length", 32'(o_l), 32'(q[0].l));
        check(o_s == q[0].s, tag, "R7 strobe", 32'(o_s), 32'(q[0].s));
        check(o_e == q[0].e, tag, "R5 row end", 32'(o_e), 32'(q[0].e));
      end
      check(o_done == m_done, "R9", "done", 32'(o_done), 32'(m_done));
      check(o_dr == (!m_busy && enable), "R11", "desc_ready", 32'(o_dr),
            32'(!m_busy && enable));
      hs  = m_busy && req_ready;
      acc = !m_busy && enable && desc_valid;
      m_done = 1'b0;
      if (hs) begin
        void'(q.pop_front());
        scen_hs++;
        if (q.size() == 0) begin
          m_busy = 1'b0;
          m_done = 1'b1;
        end else if (!enable) begin
          m_busy = 1'b0;
          q.delete();
        end
      end
      if (acc) begin
        build();
        scen_hs = 0;
        m_busy  = 1'b1;
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    req_ready = rand_on ? ($urandom_range(0, 3) != 0) : 1'b1;
  endtask

  task automatic start_desc(input logic [31:0] b, input logic [15:0] x,
                            input logic [11:0] y, input logic [31:0] s);
    bit took = 1'b0;
    desc_base = b; desc_xlen = x; desc_ylen = y; desc_stride = s;
    desc_valid = 1'b1;
    while (!took) begin
      @(negedge clk);
      took = o_dr;
      tick();
    end
    desc_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) tick();
    tick();
    tick();
  endtask

  task automatic run_desc(input string t, input logic [31:0] b, input logic [15:0] x,
                          input logic [11:0] y, input logic [31:0] s);
    tag = t;
    start_desc(b, x, y, s);
    wait_idle();
    check(scen_hs == scen_exp, t, "burst count", 32'(scen_hs), 32'(scen_exp));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (4) tick();
    @(negedge clk);
    // R9 and R11: quiet outputs while held in reset
    check(o_v == 1'b0, "R11", "reset req_valid", 32'(o_v), 0);
    check(o_done == 1'b0, "R9", "reset done", 32'(o_done), 0);
    check(o_dr == 1'b0, "R11", "reset desc_ready", 32'(o_dr), 0);
    rst_n = 1'b1;
    tick();
    enable = 1'b1;
    tick();
    // R1: 64 bytes in one row -> one burst of 8 beats
    run_desc("R1", 32'h0000_1000, 16'd63, 12'd0, 32'd0);
    // R5: 600 bytes -> 256 + 256 + 88
    run_desc("R5", 32'h0001_0000, 16'd599, 12'd0, 32'd0);
    rand_on = 1'b1;
    // R2: four rows of 32 bytes placed by stride
    run_desc("R2", 32'h0000_2000, 16'd31, 12'd3, 32'h100);
    // R4: unaligned base and stride
    run_desc("R4", 32'h0000_3005, 16'd15, 12'd1, 32'h203);
    // R7: 13-byte row and 301-byte rows with partial final beats
    run_desc("R7", 32'h0000_4000, 16'd12, 12'd0, 32'd0);
    run_desc("R7", 32'h0000_5000, 16'd300, 12'd2, 32'h200);
    // R8: long multi-row run under heavy back-pressure
    run_desc("R8", 32'h0002_0000, 16'd1023, 12'd4, 32'h800);
    // R3 and R6: one-row instance with the 16-beat protocol cap
    sel = 1'b1;
    tick();
    run_desc("R3", 32'h0000_6000, 16'd299, 12'd5, 32'h400);
    run_desc("R6", 32'h0000_7000, 16'd511, 12'd0, 32'd0);
    sel = 1'b0;
    tick();
    // R10: withdraw enable part way through
    tag = "R10";
    start_desc(32'h0003_0000, 16'd2047, 12'd3, 32'h1000);
    repeat (12) tick();
    enable = 1'b0;
    repeat (40) tick();
    @(negedge clk);
    check(o_v == 1'b0, "R10", "stopped after disable", 32'(o_v), 0);
    check(o_done == 1'b0, "R10", "no done on abort", 32'(o_done), 0);
    // R11: descriptors refused while disabled
    desc_valid = 1'b1;
    repeat (5) begin
      tick();
      @(negedge clk);
      check(o_dr == 1'b0, "R11", "refuse while disabled", 32'(o_dr), 0);
      check(o_v == 1'b0, "R11", "no request while disabled", 32'(o_v), 0);
    end
    desc_valid = 1'b0;
    tick();
    enable = 1'b1;
    tick();
    run_desc("R1", 32'h0000_8000, 16'd7, 12'd1, 32'h40);
    summary();
  end

endmodule